// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms the effective data address for a load or store from a mode code supplied by the instruction decoder. The address can be taken directly from the instruction, or it can come from one of three 16-bit pointers. Each pointer is built from a pair of the upper general-purpose registers. In the pointer modes the block can add a small unsigned displacement, pre-decrement the pointer or post-increment it. When a pointer changes, the block also produces the new pointer value and a write-back enable, so that the register file can update the pair.

The register file and the memory access sit outside this block. The block takes the six upper register bytes as a flat bus and registers its results. Each request produces its outputs exactly one clock later. Requests that cannot be carried out are flagged as illegal and never write back.

Top module: `dag_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, res_valid, wb_en and illegal are 0.
- R2: Direct mode (mode code 0) returns direct_addr unchanged as eff_addr, with any 16-bit value allowed. It asserts neither wb_en nor illegal, and ptr_sel has no effect.
- R3: Byte k of upper_regs (bits 8k+7:8k) holds register 26+k. Pointer X (ptr_sel 0) is {r27,r26}, pointer Y (ptr_sel 1) is {r29,r28}, and pointer Z (ptr_sel 2) is {r31,r30}. The high byte is the odd register.
- R4: Indirect mode (mode code 1) returns the selected pointer as eff_addr and does not write back.
- R5: Displacement mode (mode code 2) with Y or Z returns the pointer plus the zero-extended 6-bit disp (0 to 63) and does not write back.
- R6: Displacement mode with X sets illegal, clears wb_en and drives eff_addr to 0.
- R7: Pre-decrement mode (mode code 3) returns pointer minus 1 as eff_addr. It also drives wb_ptr with the same value, sets wb_en, and sets wb_sel to ptr_sel.
- R8: Post-increment mode (mode code 4) returns the old pointer as eff_addr. It drives wb_ptr with pointer plus 1, sets wb_en, and sets wb_sel to ptr_sel.
- R9: All pointer arithmetic wraps modulo 65536. 0x0000 pre-decrements to 0xFFFF, 0xFFFF post-increments to 0x0000, and a displacement sum that carries out is truncated.
- R10: A mode code of 5 to 7, or ptr_sel 3 in any pointer mode, sets illegal, clears wb_en and drives eff_addr to 0.
- R11: Every result appears on the clock edge after the request. res_valid is req_valid delayed by one cycle. When req_valid was 0, wb_en and illegal are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| direct_addr | input | 16 | Address for direct mode |
| disp | input | 6 | Unsigned displacement |
| upper_regs | input | 48 | Registers 26 to 31, byte k = register 26+k |
| res_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back |
| wb_ptr | output | 16 | New pointer value |
| illegal | output | 1 | Request could not be performed |

## Verification
Every result of this block is due one clock after the request has been sampled: the effective address, the write-back enable, the write-back select and value, and the illegal flag. The bench drives each request just after a falling edge. From the requirements it computes the expected result and holds it in a queue. At the next falling edge, after the capturing rising edge, it pops that entry and compares it with every output, so each comparison lines up with exactly one registered stage. Directed requests cover every mode on all three pointers, the wrap points, X with displacement, reserved codes and idle cycles. A random run then exercises all of these together.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_DISP    = 3'd2,
      AM_PREDEC  = 3'd3,
      AM_POSTINC = 3'd4
   } amode_e;

   localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned NUM_PTR = 3,
   parameter int unsigned SEL_W   = 2,
   localparam int unsigned PTR_W  = 2 * REG_W,
   localparam int unsigned BANK_W = 2 * NUM_PTR * REG_W
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [SEL_W-1:0]  sel,
   output logic [PTR_W-1:0]  ptr,
   output logic              sel_ok
);

   logic [PTR_W-1:0] ptr_vec [NUM_PTR];

   for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      assign ptr_vec[p] = {bank[(2*p+1)*REG_W +: REG_W], bank[(2*p)*REG_W +: REG_W]};
   end

   always_comb begin
      ptr    = '0;
      sel_ok = 1'b0;
      for (int unsigned i = 0; i < NUM_PTR; i++) begin
         if (sel == SEL_W'(i)) begin
            ptr    = ptr_vec[i];
            sel_ok = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dag_adjust.sv
module dag_adjust
   import dag_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DISP_W    = 6,
   parameter int unsigned NUM_PTR   = 3,
   parameter int unsigned SEL_W     = 2,
   parameter logic [NUM_PTR-1:0] DISP_MASK = 3'b110
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [SEL_W-1:0]  sel,
   input  logic              sel_ok,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] direct_addr,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] new_ptr,
   output logic              wb,
   output logic              bad
);

   logic [ADDR_W-1:0] ptr_dec, ptr_inc, ptr_off;
   logic              disp_ok;

   assign ptr_dec = ptr - ADDR_W'(1);
   assign ptr_inc = ptr + ADDR_W'(1);
   assign ptr_off = ptr + {{(ADDR_W-DISP_W){1'b0}}, disp};

   // Displacement permission: hard-wired per pointer through the mask
   if (DISP_MASK == '1) begin : g_disp_all
      assign disp_ok = sel_ok;
   end else begin : g_disp_mask
      always_comb begin
         disp_ok = 1'b0;
         for (int unsigned i = 0; i < NUM_PTR; i++)
            if (sel == SEL_W'(i) && DISP_MASK[i]) disp_ok = 1'b1;
      end
   end

   always_comb begin
      ea      = '0;
      new_ptr = '0;
      wb      = 1'b0;
      bad     = 1'b0;
      unique case (mode)
         AM_DIRECT: ea = direct_addr;
         AM_IND: begin
            if (sel_ok) ea = ptr;
            else        bad = 1'b1;
         end
         AM_DISP: begin
            if (disp_ok) ea = ptr_off;
            else         bad = 1'b1;
         end
         AM_PREDEC: begin
            if (sel_ok) begin
               ea      = ptr_dec;
               new_ptr = ptr_dec;
               wb      = 1'b1;
            end else bad = 1'b1;
         end
         AM_POSTINC: begin
            if (sel_ok) begin
               ea      = ptr;
               new_ptr = ptr_inc;
               wb      = 1'b1;
            end else bad = 1'b1;
         end
         default: bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/dag_out_reg.sv
module dag_out_reg #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_ea,
   input  logic [ADDR_W-1:0] in_ptr,
   input  logic              in_wb,
   input  logic              in_bad,
   input  logic [SEL_W-1:0]  in_sel,
   output logic              q_valid,
   output logic [ADDR_W-1:0] q_ea,
   output logic [ADDR_W-1:0] q_ptr,
   output logic              q_wb,
   output logic              q_bad,
   output logic [SEL_W-1:0]  q_sel
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_wb    <= 1'b0;
         q_bad   <= 1'b0;
         q_ea    <= '0;
         q_ptr   <= '0;
         q_sel   <= '0;
      end else begin
         q_valid <= in_valid;
         q_wb    <= in_valid & in_wb;
         q_bad   <= in_valid & in_bad;
         q_ea    <= in_ea;
         q_ptr   <= in_ptr;
         q_sel   <= in_sel;
      end
   end

endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
   import dag_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned NUM_PTR = 3,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DISP_W  = 6,
   parameter logic [NUM_PTR-1:0] DISP_MASK = 3'b110,
   localparam int unsigned ADDR_W = 2 * REG_W,
   localparam int unsigned BANK_W = 2 * NUM_PTR * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        mode,
   input  logic [SEL_W-1:0]  ptr_sel,
   input  logic [ADDR_W-1:0] direct_addr,
   input  logic [DISP_W-1:0] disp,
   input  logic [BANK_W-1:0] upper_regs,
   output logic              res_valid,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              wb_en,
   output logic [SEL_W-1:0]  wb_sel,
   output logic [ADDR_W-1:0] wb_ptr,
   output logic              illegal
);

   initial begin
      if (NUM_PTR > (1 << SEL_W))
         $error("dag_addr_gen: SEL_W too narrow for NUM_PTR");
      if (DISP_W >= ADDR_W)
         $error("dag_addr_gen: DISP_W must be below address width");
      if (MODE_W != 3)
         $error("dag_addr_gen: mode width mismatch");
   end

   logic [ADDR_W-1:0] cur_ptr, ea_c, new_c;
   logic              sel_ok, wb_c, bad_c;

   dag_ptr_mux #(.REG_W(REG_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_mux (
      .bank(upper_regs), .sel(ptr_sel), .ptr(cur_ptr), .sel_ok(sel_ok)
   );

   dag_adjust #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .NUM_PTR(NUM_PTR),
                .SEL_W(SEL_W), .DISP_MASK(DISP_MASK)) u_adj (
      .mode(mode), .sel(ptr_sel), .sel_ok(sel_ok), .ptr(cur_ptr),
      .direct_addr(direct_addr), .disp(disp),
      .ea(ea_c), .new_ptr(new_c), .wb(wb_c), .bad(bad_c)
   );

   dag_out_reg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .in_valid(req_valid),
      .in_ea(ea_c), .in_ptr(new_c), .in_wb(wb_c), .in_bad(bad_c), .in_sel(ptr_sel),
      .q_valid(res_valid), .q_ea(eff_addr), .q_ptr(wb_ptr), .q_wb(wb_en),
      .q_bad(illegal), .q_sel(wb_sel)
   );

endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        mode,
   input logic [SEL_W-1:0]  ptr_sel,
   input logic [ADDR_W-1:0] direct_addr,
   input logic              res_valid,
   input logic [ADDR_W-1:0] eff_addr,
   input logic              wb_en,
   input logic [SEL_W-1:0]  wb_sel,
   input logic [ADDR_W-1:0] wb_ptr,
   input logic              illegal
);

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1: flags low while reset holds
   a_r1_reset_quiet: assert property (@(posedge clk)
      !$past(rst_n) |-> (!res_valid && !wb_en && !illegal));

   // R11: valid follows request by one cycle
   a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      res_valid == $past(req_valid));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!wb_en && !illegal));

   // R2: direct address passes through, no side effects
   a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(req_valid) && $past(mode) == 3'd0) |->
         (eff_addr == $past(direct_addr) && !wb_en && !illegal));

   // R6: X with displacement is refused
   a_r6_disp_x: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(req_valid) && $past(mode) == 3'd2 && $past(ptr_sel) == '0) |->
         (illegal && !wb_en));

   // R7: pre-decrement address equals written-back pointer
   a_r7_predec_same: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(req_valid) && $past(mode) == 3'd3 && wb_en) |-> (eff_addr == wb_ptr));

   // R8: post-increment writes back one above the address used
   a_r8_postinc_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(req_valid) && $past(mode) == 3'd4 && wb_en) |->
         (wb_ptr == ADDR_W'(eff_addr + ADDR_W'(1))));

   // R10: reserved codes refused; illegal never writes back
   a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(req_valid) && $past(mode) > 3'd4) |-> (illegal && !wb_en && eff_addr == '0));

   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal && wb_en));

   // R7/R8: write-back select echoes the request
   a_r8_wbsel: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      wb_en |-> (wb_sel == $past(ptr_sel)));

endmodule

bind dag_addr_gen dag_addr_gen_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
   .ptr_sel(ptr_sel), .direct_addr(direct_addr), .res_valid(res_valid),
   .eff_addr(eff_addr), .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr),
   .illegal(illegal)
);

// File: tb/tb_dag_addr_gen.sv
module tb_dag_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [2:0]  mode;
   logic [1:0]  ptr_sel;
   logic [15:0] direct_addr;
   logic [5:0]  disp;
   logic [47:0] upper_regs;
   logic        res_valid, wb_en, illegal;
   logic [15:0] eff_addr, wb_ptr;
   logic [1:0]  wb_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      bit          v;
      bit [15:0]   ea;
      bit          wb;
      bit [1:0]    sel;
      bit [15:0]   np;
      bit          ill;
      string       tag;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   dag_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .ptr_sel(ptr_sel), .direct_addr(direct_addr), .disp(disp),
      .upper_regs(upper_regs), .res_valid(res_valid), .eff_addr(eff_addr),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr), .illegal(illegal)
   );

   task automatic chk(string tag, string what, int act, int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic exp_t model(bit v, bit [2:0] m, bit [1:0] s, bit [15:0] da,
                                  bit [5:0] d, bit [47:0] r);
      exp_t e;
      int   p;
      e.v = v; e.ea = 0; e.wb = 0; e.sel = s; e.np = 0; e.ill = 0;
      p = (s == 2'd3) ? 0 : int'({r[16*s+8 +: 8], r[16*s +: 8]});
      e.tag = "R11";
      if (!v) return e;
      case (m)
         3'd0: begin e.ea = da; e.tag = "R2"; end
         3'd1: begin e.tag = "R4"; if (s == 3) e.ill = 1; else e.ea = 16'(p); end
         3'd2: begin
            e.tag = (s == 0) ? "R6" : "R5";
            if (s == 0 || s == 3) e.ill = 1; else e.ea = 16'(p + int'(d));
         end
         3'd3: begin
            e.tag = "R7";
            if (s == 3) e.ill = 1;
            else begin e.ea = 16'(p + 65535); e.np = e.ea; e.wb = 1; end
         end
         3'd4: begin
            e.tag = "R8";
            if (s == 3) e.ill = 1;
            else begin e.ea = 16'(p); e.np = 16'(p + 1); e.wb = 1; end
         end
         default: begin e.tag = "R10"; e.ill = 1; end
      endcase
      if (s == 3 && m != 0 && m <= 4) e.tag = "R10";
      return e;
   endfunction

   task automatic compare();
      exp_t e;
      if (q.size() == 0) return;
      e = q.pop_front();
      chk(e.tag, "res_valid", int'(res_valid), int'(e.v));
      chk(e.tag, "wb_en", int'(wb_en), int'(e.v && e.wb));
      chk(e.tag, "illegal", int'(illegal), int'(e.v && e.ill));
      if (e.v && (e.wb || e.ill || e.tag == "R2" || e.tag == "R4" || e.tag == "R5"))
         chk(e.tag, "eff_addr", int'(eff_addr), int'(e.ea));
      if (e.v && e.wb) begin
         chk(e.tag, "wb_ptr", int'(wb_ptr), int'(e.np));
         chk(e.tag, "wb_sel", int'(wb_sel), int'(e.sel));
      end
   endtask

   task automatic step(bit v, bit [2:0] m, bit [1:0] s, bit [15:0] da,
                       bit [5:0] d, bit [47:0] r);
      @(negedge clk);
      compare();
      req_valid = v; mode = m; ptr_sel = s; direct_addr = da; disp = d; upper_regs = r;
      q.push_back(model(v, m, s, da, d, r));
   endtask

   // register bytes r26..r31 -> X=0x1234, Y=0x5678, Z=0x9ABC (R3)
   localparam bit [47:0] REGS_A = {8'h9A, 8'hBC, 8'h56, 8'h78, 8'h12, 8'h34};
   // X=0x0000, Y=0xFFFF, Z=0xFFF0 for wrap cases (R9)
   localparam bit [47:0] REGS_W = {8'hFF, 8'hF0, 8'hFF, 8'hFF, 8'h00, 8'h00};

   initial begin
      rst_n = 0; req_valid = 0; mode = 0; ptr_sel = 0;
      direct_addr = 0; disp = 0; upper_regs = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "res_valid", int'(res_valid), 0);
      chk("R1", "wb_en", int'(wb_en), 0);
      chk("R1", "illegal", int'(illegal), 0);
      rst_n = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "res_valid after", int'(res_valid), 0);

      // R2 direct, ptr_sel ignored
      step(1, 0, 0, 16'hFFFF, 6'd5, REGS_A);
      step(1, 0, 3, 16'h0000, 6'd0, REGS_A);
      step(1, 0, 2, 16'hA5C3, 6'd63, REGS_A);
      // R3 / R4 indirect on each pointer
      for (int s = 0; s < 3; s++) step(1, 1, 2'(s), 16'h0, 6'd0, REGS_A);
      // R5 displacement on Y and Z, R6 on X
      step(1, 2, 1, 16'h0, 6'd63, REGS_A);
      step(1, 2, 2, 16'h0, 6'd0,  REGS_A);
      step(1, 2, 0, 16'h0, 6'd10, REGS_A);
      // R7 / R8 on each pointer
      for (int s = 0; s < 3; s++) step(1, 3, 2'(s), 16'h0, 6'd0, REGS_A);
      for (int s = 0; s < 3; s++) step(1, 4, 2'(s), 16'h0, 6'd0, REGS_A);
      // R9 wrap cases
      step(1, 3, 0, 16'h0, 6'd0,  REGS_W);
      step(1, 4, 1, 16'h0, 6'd0,  REGS_W);
      step(1, 2, 2, 16'h0, 6'd63, REGS_W);
      step(1, 2, 1, 16'h0, 6'd1,  REGS_W);
      // R10 reserved modes and pointer select 3
      for (int m = 5; m < 8; m++) step(1, 3'(m), 1, 16'h1111, 6'd0, REGS_A);
      for (int m = 1; m < 5; m++) step(1, 3'(m), 3, 16'h1111, 6'd3, REGS_A);
      // R11 idle with a pointer-changing mode on the pins
      step(0, 4, 1, 16'h0, 6'd0, REGS_A);
      step(0, 5, 3, 16'h0, 6'd0, REGS_A);
      // random traffic
      for (int i = 0; i < 400; i++)
         step(1'($urandom_range(0, 3) != 0), 3'($urandom), 2'($urandom),
              16'($urandom), 6'($urandom), {16'($urandom), 32'($urandom)});
      step(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      compare();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule